// File: doc/BRIEF.md
# Dual-Buffer Transmit Command Controller

This block is the register-mapped transmit side of a small Ethernet MAC. Software fills one of two packet buffers and that buffer's length word. It then writes the buffer's control word. The control word carries two command bits. With only the start bit set, the block asks an external frame sender to transmit the buffer. With the start bit and the address bit both set, the block loads the station MAC address from the first six bytes of the buffer. In both cases the command bits clear themselves. The block can then raise a one-clock interrupt pulse.

The frame sender sees a single-cycle start strobe with a buffer index and a byte length. It answers with a done strobe. While a frame is in flight the block counts the sender as busy. The bus is 32-bit and word-aligned, and every read returns its data one clock after the read strobe. Serialisation, PHY signalling and CRC belong to the sender and are not part of this block.

Top module: `dual_txbuf_cmd`

## Requirements
- R1: After reset, `tx_start` and `irq` are 0, `station_mac` equals the `MAC_RESET` parameter, and the length and control words read back as 0.
- R2: Byte address map: buffer 0 data starts at 0x000 and buffer 1 data starts at 0x800. The length words are at 0x7F4 and 0xFF4, and the control words are at 0x7FC and 0xFFC. The global interrupt enable is at 0x7F8 and only its bit 31 is stored. Address bits [1:0] are ignored, and read data appears one cycle after `bus_rd`.
- R3: A control write stores the written word with bits 1 (P) and 0 (S) cleared and every other bit kept.
- R4: A control write with S=1 and P=0 to an idle sender makes `tx_start` high for exactly one cycle, in the cycle after the write. At the same time `tx_buf` shows the buffer index and `tx_len` shows the low `LEN_W` bits of that buffer's length word.
- R5: A send command is ignored while the sender is busy, which is from a `tx_start` until `tx_done`. A `tx_done` in the same cycle as the control write counts as idle, so that send is accepted.
- R6: A control write with S=1 and P=1 loads `station_mac` from the first six bytes of that buffer, in the cycle after the write. Byte 0 is bits [31:24] of the buffer's first word and lands in `station_mac[47:40]`. This command does not start the sender.
- R7: `irq` pulses for one cycle, in the cycle after an accepted command, only when bit 3 (I) of the written control word is 1 and the global enable bit 31 is 1. An ignored send gives no pulse.
- R8: A control write with S=0 issues no start, no interrupt and no address load.
- R9: Buffer data words, including the word of buffer 1 at 0xFF8, read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| tx_start | output | 1 | One-cycle transmit request |
| tx_buf | output | 1 | Buffer index for the request |
| tx_len | output | LEN_W | Frame length in bytes |
| tx_done | input | 1 | Sender has finished the frame |
| station_mac | output | 48 | Station MAC address |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two events can land in the same clock: the sender's `tx_done`, and a new send command written while the previous frame is still counted as busy. The bench provokes this by raising `tx_done` in the same cycle as a control write to the other buffer. It expects a start strobe for the new buffer in the following cycle. A send written while busy without `tx_done` must give neither a start nor an interrupt.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int DW      = 32;
  localparam int BIT_S   = 0;
  localparam int BIT_P   = 1;
  localparam int BIT_I   = 3;
  localparam int BIT_GIE = 31;

  typedef enum logic [1:0] {CMD_NONE, CMD_SEND, CMD_PROG} cmd_e;

  function automatic cmd_e decode_cmd(input logic [DW-1:0] w);
    if (!w[BIT_S])     return CMD_NONE;
    else if (w[BIT_P]) return CMD_PROG;
    else               return CMD_SEND;
  endfunction
endpackage

// File: rtl/txbuf_ram.sv
module txbuf_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/txbuf_chan.sv
module txbuf_chan
  import txbuf_pkg::*;
#(
  parameter int WIDX_W  = 9,
  parameter int LEN_W   = 16,
  parameter bit HAS_GIE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DW-1:0]     wdata,
  input  logic [WIDX_W-1:0] ridx,
  output logic [LEN_W-1:0]  len_q,
  output logic              gie_q,
  output logic [63:0]       hdr_q,
  output cmd_e              cmd,
  output logic              cmd_ien,
  output logic              reg_hit,
  output logic [DW-1:0]     reg_val
);
  localparam logic [WIDX_W-1:0] IDX_CTRL = WIDX_W'((1 << WIDX_W) - 1);
  localparam logic [WIDX_W-1:0] IDX_GIE  = WIDX_W'((1 << WIDX_W) - 2);
  localparam logic [WIDX_W-1:0] IDX_LEN  = WIDX_W'((1 << WIDX_W) - 3);

  logic [DW-1:0] ctrl_q;
  logic          ctrl_wr;

  assign ctrl_wr = wr_en && (widx == IDX_CTRL);
  assign cmd     = ctrl_wr ? decode_cmd(wdata) : CMD_NONE;
  assign cmd_ien = wdata[BIT_I];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      len_q  <= '0;
      hdr_q  <= '0;
    end else if (wr_en) begin
      if (ctrl_wr)           ctrl_q <= wdata & ~(DW'(1 << BIT_S) | DW'(1 << BIT_P));
      if (widx == IDX_LEN)   len_q  <= wdata[LEN_W-1:0];
      if (widx == '0)        hdr_q[63:32] <= wdata;
      if (widx == WIDX_W'(1)) hdr_q[31:0] <= wdata;
    end
  end

  generate
    if (HAS_GIE) begin : g_gie
      always_ff @(posedge clk) begin
        if (rst)                          gie_q <= 1'b0;
        else if (wr_en && widx == IDX_GIE) gie_q <= wdata[BIT_GIE];
      end
    end else begin : g_no_gie
      assign gie_q = 1'b0;
    end
  endgenerate

  always_comb begin
    reg_hit = 1'b1;
    reg_val = '0;
    if (ridx == IDX_CTRL)                reg_val = ctrl_q;
    else if (ridx == IDX_LEN)            reg_val = DW'(len_q);
    else if (HAS_GIE && ridx == IDX_GIE) reg_val = {gie_q, {(DW-1){1'b0}}};
    else                                 reg_hit = 1'b0;
  end

  // R3: the I bit written to control survives into the stored word
  p_ctrl_keeps_i_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> ctrl_q[BIT_I] == $past(wdata[BIT_I]));
endmodule

// File: rtl/tx_cmd_engine.sv
module tx_cmd_engine
  import txbuf_pkg::*;
#(
  parameter int          LEN_W     = 16,
  parameter logic [47:0] MAC_RESET = 48'h02_00_00_00_00_01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       send_req,
  input  logic [1:0]       prog_req,
  input  logic [1:0]       ien,
  input  logic             gie,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  input  logic [63:0]      hdr0,
  input  logic [63:0]      hdr1,
  input  logic             tx_done,
  output logic             tx_start,
  output logic             tx_buf,
  output logic [LEN_W-1:0] tx_len,
  output logic [47:0]      station_mac,
  output logic             irq
);
  logic busy_q, any_send, any_prog, sel, accept, ien_sel;

  assign any_send = |send_req;
  assign any_prog = |prog_req;
  assign sel      = send_req[1] | prog_req[1];
  assign accept   = any_send && (!busy_q || tx_done);
  assign ien_sel  = sel ? ien[1] : ien[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      tx_start    <= 1'b0;
      tx_buf      <= 1'b0;
      tx_len      <= '0;
      irq         <= 1'b0;
      station_mac <= MAC_RESET;
    end else begin
      tx_start <= accept;
      irq      <= gie && ien_sel && (accept || any_prog);
      if (accept) begin
        tx_buf <= sel;
        tx_len <= sel ? len1 : len0;
        busy_q <= 1'b1;
      end else if (tx_done) begin
        busy_q <= 1'b0;
      end
      if (any_prog) station_mac <= sel ? hdr1[63:16] : hdr0[63:16];
    end
  end

  // R5: a busy sender without done blocks the next start
  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tx_done) |=> !tx_start);
  // R4: a start is always the answer to a send command
  p_start_from_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(any_send));
  // R6: the station address moves only on an address command
  p_mac_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !any_prog |=> $stable(station_mac));
  // R7: no interrupt without the global enable
  p_irq_needs_gie_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie));
endmodule

// File: rtl/dual_txbuf_cmd.sv
module dual_txbuf_cmd
  import txbuf_pkg::*;
#(
  parameter int          BUF_BYTES = 2048,
  parameter int          LEN_W     = 16,
  parameter logic [47:0] MAC_RESET = 48'h02_00_00_00_00_01,
  localparam int         ADDR_W    = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_start,
  output logic              tx_buf,
  output logic [LEN_W-1:0]  tx_len,
  input  logic              tx_done,
  output logic [47:0]       station_mac,
  output logic              irq
);
  localparam int WIDX_W = $clog2(BUF_BYTES / 4);

  logic              bsel;
  logic [WIDX_W-1:0] widx;
  logic [31:0]       ram_q, rreg_q;
  logic              rsel_q;

  logic [LEN_W-1:0] len_a  [2];
  logic [63:0]      hdr_a  [2];
  logic [31:0]      rval_a [2];
  logic [1:0]       gie_a, hit_a, send_req, prog_req, ien;

  assign bsel = bus_addr[ADDR_W-1];
  assign widx = bus_addr[ADDR_W-2:2];

  txbuf_ram #(.AW(WIDX_W + 1), .DW(32)) i_ram (
    .clk(clk), .we(bus_wr), .waddr({bsel, widx}), .wdata(bus_wdata),
    .raddr({bsel, widx}), .q(ram_q)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_chan
      cmd_e c;
      txbuf_chan #(.WIDX_W(WIDX_W), .LEN_W(LEN_W), .HAS_GIE(g == 0)) i_chan (
        .clk(clk), .rst(rst), .wr_en(bus_wr && (bsel == 1'(g))), .widx(widx),
        .wdata(bus_wdata), .ridx(widx), .len_q(len_a[g]), .gie_q(gie_a[g]),
        .hdr_q(hdr_a[g]), .cmd(c), .cmd_ien(ien[g]), .reg_hit(hit_a[g]),
        .reg_val(rval_a[g])
      );
      assign send_req[g] = (c == CMD_SEND);
      assign prog_req[g] = (c == CMD_PROG);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= 1'b0;
      rreg_q <= '0;
    end else if (bus_rd) begin
      rsel_q <= hit_a[bsel];
      rreg_q <= rval_a[bsel];
    end
  end

  assign bus_rdata = rsel_q ? rreg_q : ram_q;

  tx_cmd_engine #(.LEN_W(LEN_W), .MAC_RESET(MAC_RESET)) i_eng (
    .clk(clk), .rst(rst), .send_req(send_req), .prog_req(prog_req), .ien(ien),
    .gie(gie_a[0]), .len0(len_a[0]), .len1(len_a[1]), .hdr0(hdr_a[0]),
    .hdr1(hdr_a[1]), .tx_done(tx_done), .tx_start(tx_start), .tx_buf(tx_buf),
    .tx_len(tx_len), .station_mac(station_mac), .irq(irq)
  );

  // R8: a control word written with S clear never reaches the sender
  p_no_cmd_without_s_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_wdata[0]) |=> !tx_start && !irq);
endmodule

// File: tb/test_dual_txbuf_cmd.sv
module test_dual_txbuf_cmd;
  localparam logic [47:0] MAC_RST = 48'h02_00_00_00_00_01;

  logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, tx_done = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_start, tx_buf, irq;
  logic [15:0] tx_len;
  logic [47:0] station_mac;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dual_txbuf_cmd i_dual_txbuf_cmd (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_start(tx_start),
    .tx_buf(tx_buf), .tx_len(tx_len), .tx_done(tx_done),
    .station_mac(station_mac), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic done = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tx_done = done;
    @(negedge clk);
    bus_wr = 1'b0; tx_done = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 tx_start", tx_start, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mac", station_mac, MAC_RST);
    rd(12'h7FC, d); chk("R1 ctrl0", d, 0);
    rd(12'hFF4, d); chk("R1 len1", d, 0);
  endtask

  task automatic t_data();
    logic [31:0] d;
    wr(12'h008, 32'hCAFE_0001);
    wr(12'h806, 32'h1234_5678);
    wr(12'hFF8, 32'hA5A5_5A5A);
    rd(12'h008, d); chk("R9 buf0 word", d, 32'hCAFE_0001);
    rd(12'h804, d); chk("R2 R9 addr[1:0] ignored", d, 32'h1234_5678);
    rd(12'hFF8, d); chk("R9 buf1 0xFF8 data", d, 32'hA5A5_5A5A);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(12'h7F4, 32'd60);
    wr(12'hFF4, 32'h123);
    wr(12'h7F8, 32'hFFFF_FFFF);
    rd(12'h7F4, d); chk("R2 len0", d, 60);
    rd(12'hFF4, d); chk("R2 len1", d, 32'h123);
    rd(12'h7F8, d); chk("R2 gie bit31 only", d, 32'h8000_0000);
  endtask

  task automatic t_send();
    logic [31:0] d;
    wr(12'h7FC, 32'h0000_0109);
    chk("R4 start", tx_start, 1);
    chk("R4 buf", tx_buf, 0);
    chk("R4 len", tx_len, 60);
    chk("R7 irq on send", irq, 1);
    @(negedge clk);
    chk("R4 start one cycle", tx_start, 0);
    chk("R7 irq one cycle", irq, 0);
    rd(12'h7FC, d); chk("R3 ctrl0 S cleared", d, 32'h108);
  endtask

  task automatic t_busy();
    wr(12'hFFC, 32'h9);
    chk("R5 busy ignores send", tx_start, 0);
    chk("R7 no irq on ignored", irq, 0);
    done_pulse();
    wr(12'hFFC, 32'h1);
    chk("R4 start buf1", tx_start, 1);
    chk("R4 buf1 index", tx_buf, 1);
    chk("R4 buf1 len", tx_len, 16'h123);
    chk("R7 no irq without I", irq, 0);
  endtask

  task automatic t_collide();
    wr(12'h7FC, 32'h1, 1'b1);
    chk("R5 done same cycle accepted", tx_start, 1);
    chk("R5 buf0 after collide", tx_buf, 0);
    done_pulse();
  endtask

  task automatic t_prog();
    logic [31:0] d;
    wr(12'h800, 32'h0011_2233);
    wr(12'h804, 32'h4455_6677);
    wr(12'hFFC, 32'hB);
    chk("R6 mac loaded", station_mac, 48'h0011_2233_4455);
    chk("R6 no start", tx_start, 0);
    chk("R7 irq on prog", irq, 1);
    rd(12'hFFC, d); chk("R3 ctrl1 P,S cleared", d, 32'h8);
  endtask

  task automatic t_gie_off();
    wr(12'h7F8, 32'h0);
    wr(12'h7FC, 32'h9);
    chk("R4 start gie off", tx_start, 1);
    chk("R7 gie gates irq", irq, 0);
    done_pulse();
    wr(12'h7F8, 32'h8000_0000);
  endtask

  task automatic t_idle();
    logic [31:0] d;
    wr(12'h000, 32'hDEAD_BEEF);
    wr(12'h7FC, 32'hA);
    chk("R8 P only no start", tx_start, 0);
    chk("R8 no irq", irq, 0);
    chk("R8 mac kept", station_mac, 48'h0011_2233_4455);
    wr(12'h7FC, 32'h8);
    chk("R8 S=0 no start", tx_start, 0);
    rd(12'h7FC, d); chk("R3 ctrl0 stored", d, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_data();
    t_regs();
    t_send();
    t_busy();
    t_collide();
    t_prog();
    t_gie_off();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule